// File: doc/BRIEF.md
# Byte-Buffered Asynchronous Serial Port

This block is the asynchronous serial port of a small controller. Software reaches it through a tiny register window. A single data address hides two separate byte registers. A write loads the transmit shifter, which at once sends the byte on `txd_o`: a low start bit, eight data bits least significant first, then a high stop bit. A read returns the receive holding register. That register is filled only when the receiver has taken a complete frame from `rxd_i`, stripped its framing bits and found a valid stop bit.

A control register holds the receive enable and two sticky completion flags, one for each direction. Software clears a flag by writing zero to its bit. Both flags feed one interrupt line. A separate power-control register carries a doubling bit, which halves the oversampling tick period and so doubles the bit rate.

All bit timing comes from a shared 16x oversampling tick. The receiver detects the falling edge of a start bit and samples every bit at its midpoint.

Top module: `sport_uart`

## Requirements
- R1: After reset `txd_o` is high, `irq_o` is low, and the control register (address 1) and the power register (address 2) both read zero.
- R2: A write to address 0 starts a frame on `txd_o`. The frame is a low start bit, then the eight data bits least significant bit first, then a high stop bit. At the normal rate each bit lasts 16 × OVS_DIV clock cycles.
- R3: The transmit flag (control bit 1) becomes 1 as the stop bit begins and remains 1 until software clears it.
- R4: A read of address 0 returns the last byte received, never the byte most recently written for transmission.
- R5: A frame received with the receiver enabled and a high stop bit places its data byte in the receive register and sets the receive flag (control bit 0). A low pulse on `rxd_i` that has ended before the midpoint of the start bit starts no frame.
- R6: While the receive enable (control bit 4) is 0, incoming frames leave both the receive flag and the receive register unchanged.
- R7: A frame whose stop bit is sampled low leaves both the receive flag and the receive register unchanged.
- R8: Power register bit 7 resets to 0. When it is set to 1, each transmitted bit lasts 8 × OVS_DIV clock cycles.
- R9: `irq_o` is high exactly while at least one of the two flags is set. Writing 0 to a flag bit clears that flag. Writing 1 to a flag bit does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 2 | Register select: 0 data, 1 control, 2 power |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the register at `reg_addr` |
| rxd_i | input | 1 | Serial receive line, idles high |
| txd_o | output | 1 | Serial transmit line, idles high |
| irq_o | output | 1 | Combined serial interrupt request |

## Verification
A wrong internal state shows at the ports in three ways, all within one frame time:

- A transmit shifter fault shows on `txd_o` as a wrong bit value, or as a bit whose length differs from the programmed rate. The bench samples every bit at its centre, so either fault appears in the next frame.
- A receiver that samples at the wrong point, accepts a glitch, or ignores the enable or the stop-bit check is caught after one frame. The control flags or the data register then read back wrong, either at the end of the frame or after the rejected pulse.
- Flag or interrupt faults show on `irq_o` right after a completion or a clearing write.

// File: rtl/sport_pkg.sv
// Shared definitions for the serial port: state encodings and register map.
package sport_pkg;
    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_t;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_PWR  = 2'd2;

    localparam int CTRL_RXF_BIT = 0;
    localparam int CTRL_TXF_BIT = 1;
    localparam int CTRL_REN_BIT = 4;
    localparam int PWR_DBL_BIT  = 7;
endpackage

// File: rtl/sport_baud.sv
// Oversampling tick generator.
// Emits a one-cycle tick every OVS_DIV clocks, or every OVS_DIV/2 clocks
// when dbl is high. Assumes OVS_DIV is even and at least 4.
module sport_baud #(
    parameter int OVS_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dbl,
    output logic tick
);
    localparam int CW = (OVS_DIV > 2) ? $clog2(OVS_DIV) : 1;
    localparam logic [CW-1:0] LIM_NORM = CW'(OVS_DIV - 1);
    localparam logic [CW-1:0] LIM_DBL  = CW'(OVS_DIV / 2 - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    // Select the terminal count for the current rate.
    always_comb lim = dbl ? LIM_DBL : LIM_NORM;

    // Divide the clock and pulse tick at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= lim) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    assert_tick_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/sport_tx.sv
// Transmit shifter.
// On load it sends start(0), DATA_W bits LSB first, then stop(1). Each bit
// lasts OVS ticks. done pulses for one cycle as the stop bit begins.
// A load while busy restarts the frame with the new byte.
module sport_tx
    import sport_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    output logic              txd,
    output logic              done
);
    localparam int OW = $clog2(OVS);
    localparam int IW = $clog2(DATA_W);
    localparam logic [OW-1:0] OVS_LAST = OW'(OVS - 1);
    localparam logic [IW-1:0] BIT_LAST = IW'(DATA_W - 1);

    tx_state_t         state;
    logic [OW-1:0]     tcnt;
    logic [IW-1:0]     idx;
    logic [DATA_W-1:0] shreg;

    // Frame sequencer: advances one bit every OVS ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            tcnt  <= '0;
            idx   <= '0;
            shreg <= '0;
            txd   <= 1'b1;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                state <= TX_START;
                tcnt  <= '0;
                shreg <= data;
                txd   <= 1'b0;
            end else if (tick && state != TX_IDLE) begin
                if (tcnt == OVS_LAST) begin
                    tcnt <= '0;
                    case (state)
                        TX_START: begin
                            state <= TX_DATA;
                            idx   <= '0;
                            txd   <= shreg[0];
                            shreg <= shreg >> 1;
                        end
                        TX_DATA: begin
                            if (idx == BIT_LAST) begin
                                state <= TX_STOP;
                                txd   <= 1'b1;
                                done  <= 1'b1;
                            end else begin
                                idx   <= idx + 1'b1;
                                txd   <= shreg[0];
                                shreg <= shreg >> 1;
                            end
                        end
                        default: state <= TX_IDLE;
                    endcase
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
            end
        end
    end

    assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_IDLE) |-> txd);
    assert_done_at_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (state == TX_STOP && txd));
endmodule

// File: rtl/sport_rx.sv
// Receiver.
// Synchronises rxd and waits for a falling edge while enabled. It confirms the
// start bit at its midpoint, then samples each data bit one bit time later.
// On a high stop bit it updates hold and pulses done. Dropping en aborts any
// frame in progress.
module sport_rx
    import sport_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              en,
    input  logic              rxd,
    output logic [DATA_W-1:0] hold,
    output logic              done
);
    localparam int OW = $clog2(OVS);
    localparam int IW = $clog2(DATA_W);
    localparam logic [OW-1:0] OVS_LAST = OW'(OVS - 1);
    localparam logic [OW-1:0] OVS_MID  = OW'(OVS / 2 - 1);
    localparam logic [IW-1:0] BIT_LAST = IW'(DATA_W - 1);

    logic [SYNC_STAGES-1:0] sync;
    logic                   line, line_d;
    rx_state_t              state;
    logic [OW-1:0]          tcnt;
    logic [IW-1:0]          idx;
    logic [DATA_W-1:0]      shreg;

    // Synchroniser chain for the asynchronous line.
    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
            if (s == 0) begin : g_first
                always_ff @(posedge clk) sync[0] <= !rst_n ? 1'b1 : rxd;
            end else begin : g_next
                always_ff @(posedge clk) sync[s] <= !rst_n ? 1'b1 : sync[s-1];
            end
        end
    endgenerate

    assign line = sync[SYNC_STAGES-1];

    // Delayed copy of the line for edge detection.
    always_ff @(posedge clk) line_d <= !rst_n ? 1'b1 : line;

    // Frame sequencer: start check, data sampling, stop check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            tcnt  <= '0;
            idx   <= '0;
            shreg <= '0;
            hold  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!en) begin
                state <= RX_IDLE;
            end else if (state == RX_IDLE) begin
                if (line_d && !line) begin
                    state <= RX_START;
                    tcnt  <= '0;
                end
            end else if (tick) begin
                case (state)
                    RX_START: begin
                        if (tcnt == OVS_MID) begin
                            tcnt  <= '0;
                            idx   <= '0;
                            state <= line ? RX_IDLE : RX_DATA;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (tcnt == OVS_LAST) begin
                            tcnt  <= '0;
                            shreg <= {line, shreg[DATA_W-1:1]};
                            if (idx == BIT_LAST) state <= RX_STOP;
                            else                 idx   <= idx + 1'b1;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    default: begin
                        if (tcnt == OVS_LAST) begin
                            tcnt  <= '0;
                            state <= RX_IDLE;
                            if (line) begin
                                hold <= shreg;
                                done <= 1'b1;
                            end
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    assert_ignored_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == RX_IDLE && !done));
    assert_hold_only_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> ($stable(hold) || done));
endmodule

// File: rtl/sport_uart.sv
// Byte-buffered serial port top.
// Decodes a three-register window: data (write goes to the transmitter, read
// comes from the receiver), control (flags and receive enable) and power
// (rate doubling). Flags are set by hardware and cleared by writing 0.
// irq_o is the OR of the two flags.
module sport_uart
    import sport_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int OVS     = 16,
    parameter int OVS_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              rxd_i,
    output logic              txd_o,
    output logic              irq_o
);
    logic              tick;
    logic              dbl;
    logic              rx_en;
    logic              tx_flag, rx_flag;
    logic              tx_done, rx_done;
    logic [DATA_W-1:0] rx_hold;
    logic              wr_data, wr_ctrl, wr_pwr;

    // Decode write strobes for each register.
    always_comb begin
        wr_data = reg_wr && reg_addr == ADDR_DATA;
        wr_ctrl = reg_wr && reg_addr == ADDR_CTRL;
        wr_pwr  = reg_wr && reg_addr == ADDR_PWR;
    end

    sport_baud #(.OVS_DIV(OVS_DIV)) u_baud (
        .clk(clk), .rst_n(rst_n), .dbl(dbl), .tick(tick));

    sport_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(wr_data),
        .data(reg_wdata), .txd(txd_o), .done(tx_done));

    sport_rx #(.DATA_W(DATA_W), .OVS(OVS), .SYNC_STAGES(2)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(rx_en), .rxd(rxd_i),
        .hold(rx_hold), .done(rx_done));

    // Control and power registers; a hardware flag set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbl     <= 1'b0;
            rx_en   <= 1'b0;
            tx_flag <= 1'b0;
            rx_flag <= 1'b0;
        end else begin
            if (wr_pwr) dbl <= reg_wdata[PWR_DBL_BIT];
            if (wr_ctrl) rx_en <= reg_wdata[CTRL_REN_BIT];
            if (tx_done) tx_flag <= 1'b1;
            else if (wr_ctrl && !reg_wdata[CTRL_TXF_BIT]) tx_flag <= 1'b0;
            if (rx_done) rx_flag <= 1'b1;
            else if (wr_ctrl && !reg_wdata[CTRL_RXF_BIT]) rx_flag <= 1'b0;
        end
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_DATA: reg_rdata = rx_hold;
            ADDR_CTRL: begin
                reg_rdata[CTRL_RXF_BIT] = rx_flag;
                reg_rdata[CTRL_TXF_BIT] = tx_flag;
                reg_rdata[CTRL_REN_BIT] = rx_en;
            end
            ADDR_PWR:  reg_rdata[PWR_DBL_BIT] = dbl;
            default:   reg_rdata = '0;
        endcase
    end

    // Combined interrupt request.
    assign irq_o = tx_flag | rx_flag;

    assert_tx_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_flag && !wr_ctrl) |=> tx_flag);
    assert_flag_rise_on_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_flag) |-> txd_o);
    assert_rx_flag_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_flag) |-> $past(rx_en));
    assert_no_set_by_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_flag && !rx_done) |=> !rx_flag);
endmodule

// File: tb/sport_uart_test.sv
// Directed bench for the serial port: one task per scenario.
module sport_uart_test;
    localparam int CLK_PERIOD = 10;
    localparam int OVS_DIV    = 4;
    localparam int BT         = 16 * OVS_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       rxd_i = 1'b1;
    logic       txd_o;
    logic       irq_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sport_uart #(.DATA_W(8), .OVS(16), .OVS_DIV(OVS_DIV)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rxd_i(rxd_i),
        .txd_o(txd_o), .irq_o(irq_o));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic drive_frame(input logic [7:0] b, input logic stop_lvl);
        @(negedge clk);
        rxd_i = 1'b0;
        repeat (BT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd_i = b[i];
            repeat (BT) @(negedge clk);
        end
        rxd_i = stop_lvl;
        repeat (BT) @(negedge clk);
        rxd_i = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    // R1: reset values at the ports and in the registers.
    task automatic test_reset();
        logic [7:0] v;
        check("R1 txd idle", int'(txd_o), 1);
        check("R1 irq", int'(irq_o), 0);
        reg_read(2'd1, v); check("R1 control", int'(v), 0);
        reg_read(2'd2, v); check("R8 power reset", int'(v), 0);
    endtask

    // R2/R3/R8: transmit a byte and check every bit centre and the flag.
    task automatic test_tx(input logic [7:0] b, input int bt, input string tag);
        logic [7:0] v;
        int wait_cnt;
        reg_write(2'd0, b);
        wait_cnt = 0;
        while (txd_o !== 1'b0 && wait_cnt < 200) begin
            @(negedge clk); wait_cnt++;
        end
        repeat (bt/2) @(negedge clk);
        check({tag, " start bit"}, int'(txd_o), 0);
        for (int i = 0; i < 8; i++) begin
            repeat (bt) @(negedge clk);
            check({tag, " data bit"}, int'(txd_o), int'(b[i]));
        end
        reg_read(2'd1, v);
        check("R3 tx flag clear before stop", int'(v[1]), 0);
        repeat (bt - 1) @(negedge clk);
        check({tag, " stop bit"}, int'(txd_o), 1);
        reg_read(2'd1, v);
        check("R3 tx flag set at stop", int'(v[1]), 1);
        check("R9 irq from tx flag", int'(irq_o), 1);
        repeat (bt) @(negedge clk);
        reg_read(2'd1, v);
        check("R3 tx flag stays set", int'(v[1]), 1);
    endtask

    // R9: clearing and non-setting writes to the flag bits.
    task automatic test_clear();
        logic [7:0] v;
        reg_write(2'd1, 8'h10);
        reg_read(2'd1, v);
        check("R9 flags cleared", int'(v & 8'h03), 0);
        check("R9 irq low after clear", int'(irq_o), 0);
        reg_write(2'd1, 8'h13);
        reg_read(2'd1, v);
        check("R9 write of one does not set", int'(v & 8'h03), 0);
        check("R9 irq still low", int'(irq_o), 0);
    endtask

    // R5/R4: good frame received; data read is not the transmitted byte.
    task automatic test_rx_good(input logic [7:0] b);
        logic [7:0] v;
        drive_frame(b, 1'b1);
        reg_read(2'd1, v);
        check("R5 rx flag set", int'(v[0]), 1);
        check("R9 irq from rx flag", int'(irq_o), 1);
        reg_read(2'd0, v);
        check("R5 rx data", int'(v), int'(b));
    endtask

    // R5: short low glitch must not start a frame.
    task automatic test_glitch(input logic [7:0] prev);
        logic [7:0] v;
        @(negedge clk);
        rxd_i = 1'b0;
        repeat (BT/4) @(negedge clk);
        rxd_i = 1'b1;
        repeat (11 * BT) @(negedge clk);
        reg_read(2'd1, v);
        check("R5 glitch rejected flag", int'(v[0]), 0);
        reg_read(2'd0, v);
        check("R5 glitch data unchanged", int'(v), int'(prev));
    endtask

    // R7: frame with a low stop bit is discarded.
    task automatic test_bad_stop(input logic [7:0] prev);
        logic [7:0] v;
        drive_frame(8'h5A, 1'b0);
        repeat (BT) @(negedge clk);
        reg_read(2'd1, v);
        check("R7 bad stop no flag", int'(v[0]), 0);
        reg_read(2'd0, v);
        check("R7 bad stop data kept", int'(v), int'(prev));
    endtask

    // R6: receiver disabled ignores frames.
    task automatic test_rx_off(input logic [7:0] prev);
        logic [7:0] v;
        reg_write(2'd1, 8'h00);
        drive_frame(8'hC3, 1'b1);
        reg_read(2'd1, v);
        check("R6 disabled no flag", int'(v[0]), 0);
        reg_read(2'd0, v);
        check("R6 disabled data kept", int'(v), int'(prev));
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_tx(8'hA5, BT, "R2");
        test_clear();
        test_rx_good(8'h96);
        reg_write(2'd1, 8'h10);
        test_tx(8'h3C, BT, "R2 second pattern");
        reg_read(2'd0, v);
        check("R4 read returns received byte", int'(v), 8'h96);
        reg_write(2'd1, 8'h10);
        test_glitch(8'h96);
        test_bad_stop(8'h96);
        test_rx_good(8'h01);
        test_rx_off(8'h01);
        reg_write(2'd1, 8'h00);
        reg_write(2'd2, 8'h80);
        reg_read(2'd2, v);
        check("R8 double bit set", int'(v), 8'h80);
        test_tx(8'hE1, BT/2, "R8");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule